// File: doc/BRIEF.md
# I2C Command and Parameter Slave Front End

This block connects a display controller core to a two-wire I2C bus as a slave. A master opens a transaction with START, then sends a 7-bit device address and a direction bit. A write transaction carries one command byte, followed by any number of parameter bytes. The block hands each received byte to the core as a one-cycle strobe with the byte value. A flag tells the core whether the byte is the command or a parameter. To read display memory, the master writes the read command, issues a repeated START with the direction bit set, and clocks bytes out. The block fetches each byte from a read port on the core.

SCL and SDA are sampled with a system clock that runs much faster than the bus. Each line passes through a two-flop synchroniser and a three-sample majority filter. The filter takes one sample every `SAMPLE_DIV` clocks, so short spikes never reach the edge detector. The block drives SDA only by pulling it low: `sda_oe` high means the pad pulls the line to ground. Otherwise the line is released.

Top module: `i2c_cmd_slave`

## Requirements
- R1: While reset is held and straight after it, `sda_oe`, `byte_valid` and `rd_req` are 0.
- R2: An address byte whose upper seven bits, sent first, are 0,1,1,0 followed by `dev_id[2:0]` (bit 2 first) is acknowledged. The slave pulls SDA low during the ninth clock, and the eighth bit selects read (1) or write (0).
- R3: When the address does not match, SDA stays released for that byte and for every later byte, and no byte is strobed, until the next START.
- R4: In a write transaction, every received byte gives exactly one one-cycle `byte_valid` pulse, with `byte_data` holding the byte (first bus bit in bit 7). `is_cmd` is 1 for the first byte after the address and 0 for all later bytes.
- R5: Every byte received in an addressed write transaction is acknowledged with SDA low on its ninth clock.
- R6: After a repeated START with the read bit, the slave outputs bytes MSB first. Before each byte's first bit, it pulses `rd_req` for one cycle and takes `rd_data` as it stands two clocks after that pulse.
- R7: A master NACK (SDA high on the ninth clock) ends the read. No further `rd_req` follows and SDA stays released.
- R8: A pulse on SCL or SDA shorter than `SAMPLE_DIV` system clocks has no effect on the received bytes or on the bus state.
- R9: A STOP or a START that arrives in the middle of a byte discards the partial byte without a strobe. A START begins a new address phase.
- R10: After a repeated START inside a write transaction, the first byte after the new address is again tagged as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL as seen at the pad |
| sda_i | input | 1 | SDA as seen at the pad |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release it |
| dev_id | input | 3 | Low three bits of the slave address |
| byte_valid | output | 1 | One-cycle strobe for a received byte |
| byte_data | output | 8 | Received byte, valid with `byte_valid` |
| is_cmd | output | 1 | 1 = command byte, 0 = parameter byte |
| rd_req | output | 1 | One-cycle request for the next read byte |
| rd_data | input | 8 | Read byte, valid two clocks after `rd_req` |

## Verification
Random write transactions carry from zero to three bytes of random values. They confirm that the command/parameter tag depends only on byte position, and that byte values are assembled MSB first. Directed patterns cover the remaining paths: addresses that differ only in the low bits or only in the fixed bits, to check matching; a STOP and a START cut into a byte, to separate an abort from a byte that completes; and a repeated START within a write, which must reset the command tag. Read transactions of one to three bytes check that the request count follows the master's ACK/NACK sequence. Injected spikes on SCL and on SDA, placed where they would otherwise look like an extra clock edge or a false START or STOP, show that the filter removes them.

// File: rtl/i2c_cmd_slave.sv
module i2c_cmd_slave #(
  parameter int         SAMPLE_DIV = 7,
  parameter logic [3:0] ADDR_HI    = 4'b0110
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_id,
  output logic       byte_valid,
  output logic [7:0] byte_data,
  output logic       is_cmd,
  output logic       rd_req,
  input  logic [7:0] rd_data
);
  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WBYTE, S_WACK, S_RBYTE, S_RACK} st_t;

  function automatic logic maj3(input logic [2:0] h);
    return (h[0] & h[1]) | (h[1] & h[2]) | (h[0] & h[2]);
  endfunction

  logic [1:0]       scl_s, sda_s;
  logic [2:0]       scl_h, sda_h;
  logic [DIV_W-1:0] div_q;
  logic             scl_f, sda_f, scl_q, sda_q;

  wire tick      = (div_q == DIV_W'(SAMPLE_DIV - 1));
  wire scl_rise  = scl_f & ~scl_q;
  wire scl_fall  = ~scl_f & scl_q;
  wire start_det = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_det  = scl_f & scl_q & ~sda_q & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;  sda_s <= 2'b11;
      scl_h <= 3'b111; sda_h <= 3'b111;
      div_q <= '0;
      scl_f <= 1'b1;   sda_f <= 1'b1;
      scl_q <= 1'b1;   sda_q <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) begin
        scl_h <= {scl_h[1:0], scl_s[1]};
        sda_h <= {sda_h[1:0], sda_s[1]};
      end
      scl_f <= maj3(scl_h);
      sda_f <= maj3(sda_h);
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sh;
  logic       rw, first, rd_wait, m_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0;
      rw <= 1'b0; first <= 1'b0; rd_wait <= 1'b0; m_ack <= 1'b0;
      sda_oe <= 1'b0; byte_valid <= 1'b0; byte_data <= '0;
      is_cmd <= 1'b0; rd_req <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      rd_req     <= 1'b0;
      rd_wait    <= rd_req;
      if (rd_wait) sh <= rd_data;
      if (start_det) begin
        st <= S_ADDR; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= S_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_WBYTE: begin
            if (scl_rise && cnt < 4'd8) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (st == S_ADDR) begin
                if (sh[7:1] == {ADDR_HI, dev_id}) begin
                  st <= S_AACK; sda_oe <= 1'b1;
                  rw <= sh[0];  first <= 1'b1;
                  if (sh[0]) rd_req <= 1'b1;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                byte_valid <= 1'b1; byte_data <= sh; is_cmd <= first;
                first <= 1'b0; st <= S_WACK; sda_oe <= 1'b1;
              end
            end
          end
          S_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw) begin st <= S_RBYTE; sda_oe <= ~sh[7]; end
            else    begin st <= S_WBYTE; sda_oe <= 1'b0;   end
          end
          S_WACK: if (scl_fall) begin
            st <= S_WBYTE; cnt <= '0; sda_oe <= 1'b0;
          end
          S_RBYTE: if (scl_fall) begin
            if (cnt == 4'd7) begin
              st <= S_RACK; sda_oe <= 1'b0; m_ack <= 1'b0;
            end else begin
              sh <= {sh[6:0], 1'b0}; sda_oe <= ~sh[6]; cnt <= cnt + 4'd1;
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_f;
              if (!sda_f) rd_req <= 1'b1;
            end else if (scl_fall) begin
              if (m_ack) begin st <= S_RBYTE; cnt <= '0; sda_oe <= ~sh[7]; end
              else st <= S_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_cmd_slave_chk.sv
module i2c_cmd_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_f,
  input logic stop_det,
  input logic sda_oe,
  input logic byte_valid,
  input logic rd_req
);
  // R2 / R6: the slave only moves SDA while the filtered clock is low
  a_r2_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_f);

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);

  a_r4_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  a_r4_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && byte_valid));
endmodule

bind i2c_cmd_slave i2c_cmd_slave_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .stop_det(stop_det),
  .sda_oe(sda_oe), .byte_valid(byte_valid), .rd_req(rd_req)
);

// File: tb/i2c_cmd_slave_tb_top.sv
module i2c_cmd_slave_tb_top;
  localparam int Q = 32;
  localparam logic [3:0] AHI = 4'b0110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe, byte_valid, is_cmd, rd_req;
  logic [7:0] byte_data;
  logic [7:0] rd_data = 8'h00;
  logic [2:0] dev_id = 3'b101;
  wire sda_bus = m_sda & ~sda_oe;

  int tests = 0, fails = 0;
  logic [7:0] rx_data [512];
  logic       rx_cmd  [512];
  int rx_n = 0, rd_n = 0;
  logic [7:0] wbuf [8];

  i2c_cmd_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_id(dev_id), .byte_valid(byte_valid), .byte_data(byte_data),
    .is_cmd(is_cmd), .rd_req(rd_req), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 29 + 75);
  endfunction

  always @(posedge clk) begin
    if (byte_valid) begin
      rx_data[rx_n] <= byte_data;
      rx_cmd[rx_n]  <= is_cmd;
      rx_n <= rx_n + 1;
    end
    if (rd_req) begin
      rd_data <= pat(rd_n);
      rd_n <= rd_n + 1;
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  // g: 0 none, 1 SDA spike while SCL high, 2 SCL spike while SCL low
  task automatic send_bit(input logic b, input int g);
    m_sda = b; wq(); m_scl = 1'b1;
    if (g == 1) begin
      repeat (20) @(negedge clk); m_sda = ~b; repeat (5) @(negedge clk); m_sda = b;
    end
    wq(); wq(); m_scl = 1'b0;
    if (g == 2) begin
      repeat (20) @(negedge clk); m_scl = 1'b1; repeat (5) @(negedge clk); m_scl = 1'b0;
    end
    wq();
  endtask

  task automatic write_byte(input logic [7:0] b, input int gk, input int gpos, output logic a);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (i == gpos) ? gk : 0);
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); a = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic read_byte(input logic ack, output logic [7:0] b);
    b = 8'h00;
    for (int i = 0; i < 8; i++) begin
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); m_scl = 1'b0; wq();
    end
    send_bit(~ack, 0);
  endtask

  task automatic do_write(input int n, input int gk, input int gpos);
    int base; logic a;
    base = rx_n;
    i2c_start();
    write_byte({AHI, dev_id, 1'b0}, 0, 9, a);
    check(a == 1'b0, "R2 write address ack", a, 0);
    for (int i = 0; i < n; i++) begin
      write_byte(wbuf[i], (i == 0) ? gk : 0, gpos, a);
      check(a == 1'b0, "R5 byte ack", a, 0);
    end
    i2c_stop(); wq();
    check(rx_n - base == n, "R4 strobe count", rx_n - base, n);
    for (int i = 0; i < n && i < rx_n - base; i++) begin
      check(rx_data[base + i] == wbuf[i], "R4 byte value", rx_data[base + i], wbuf[i]);
      check(rx_cmd[base + i] == (i == 0), "R4 is_cmd tag", rx_cmd[base + i], (i == 0));
    end
  endtask

  task automatic do_read(input int n);
    int base, rbase; logic a; logic [7:0] b;
    base = rx_n;
    i2c_start();
    write_byte({AHI, dev_id, 1'b0}, 0, 9, a);
    check(a == 1'b0, "R2 address ack before read", a, 0);
    write_byte(8'h08, 0, 9, a);
    check(a == 1'b0, "R5 read command ack", a, 0);
    rbase = rd_n;
    i2c_start();
    write_byte({AHI, dev_id, 1'b1}, 0, 9, a);
    check(a == 1'b0, "R6 read address ack", a, 0);
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, b);
      check(b == pat(rbase + i), "R6 read byte", b, pat(rbase + i));
    end
    wq();
    check(sda_oe == 1'b0, "R7 SDA released after NACK", sda_oe, 0);
    i2c_stop(); wq();
    check(rd_n - rbase == n, "R7 request count", rd_n - rbase, n);
    check(rx_n - base == 1 && rx_cmd[base] == 1'b1, "R4 read command tagged", rx_n - base, 1);
  endtask

  initial begin
    logic a;
    int base;
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    check(sda_oe == 0 && byte_valid == 0 && rd_req == 0, "R1 outputs in reset",
          {sda_oe, byte_valid, rd_req}, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    check(sda_oe == 0 && byte_valid == 0 && rd_req == 0, "R1 outputs after reset",
          {sda_oe, byte_valid, rd_req}, 0);

    wbuf[0] = 8'h1A; wbuf[1] = 8'h80; wbuf[2] = 8'h01;
    do_write(3, 0, 9);

    // R3 low-bit mismatch, then fixed-bit mismatch
    base = rx_n;
    i2c_start();
    write_byte({AHI, dev_id ^ 3'b010, 1'b0}, 0, 9, a);
    check(a == 1'b1, "R3 no ack on id mismatch", a, 1);
    write_byte(8'h00, 0, 9, a);
    check(a == 1'b1, "R3 stays released", a, 1);
    i2c_stop(); wq();
    i2c_start();
    write_byte({4'b0111, dev_id, 1'b0}, 0, 9, a);
    check(a == 1'b1, "R3 no ack on fixed-bit mismatch", a, 1);
    i2c_stop(); wq();
    check(rx_n == base, "R3 no strobe", rx_n - base, 0);

    // R9 STOP inside a byte
    base = rx_n;
    i2c_start();
    write_byte({AHI, dev_id, 1'b0}, 0, 9, a);
    write_byte(8'h5C, 0, 9, a);
    for (int i = 0; i < 4; i++) send_bit(1'b0, 0);
    i2c_stop(); wq();
    check(rx_n - base == 1, "R9 STOP drops partial byte", rx_n - base, 1);

    // R9 START inside a byte, R10 tag after repeated START
    base = rx_n;
    i2c_start();
    write_byte({AHI, dev_id, 1'b0}, 0, 9, a);
    write_byte(8'h21, 0, 9, a);
    write_byte(8'h22, 0, 9, a);
    for (int i = 0; i < 3; i++) send_bit(1'b1, 0);
    i2c_start();
    write_byte({AHI, dev_id, 1'b0}, 0, 9, a);
    check(a == 1'b0, "R9 address after START abort", a, 0);
    write_byte(8'h33, 0, 9, a);
    write_byte(8'h44, 0, 9, a);
    i2c_stop(); wq();
    check(rx_n - base == 4, "R9 START drops partial byte", rx_n - base, 4);
    check(rx_cmd[base + 2] == 1'b1 && rx_data[base + 2] == 8'h33, "R10 command after repeated START",
          rx_data[base + 2], 8'h33);
    check(rx_cmd[base + 3] == 1'b0, "R10 parameter after repeated START", rx_cmd[base + 3], 0);

    // R8 spikes: SDA spike on a 1 bit (false START) and on a 0 bit (false STOP), SCL spike
    wbuf[0] = 8'hA6; wbuf[1] = 8'h3C;
    do_write(2, 1, 7);
    check(rx_data[rx_n - 2] == 8'hA6, "R8 SDA spike on high bit", rx_data[rx_n - 2], 8'hA6);
    wbuf[0] = 8'h59;
    do_write(1, 1, 7);
    check(rx_data[rx_n - 1] == 8'h59, "R8 SDA spike on low bit", rx_data[rx_n - 1], 8'h59);
    wbuf[0] = 8'hC3; wbuf[1] = 8'h0F;
    do_write(2, 2, 4);
    check(rx_data[rx_n - 2] == 8'hC3, "R8 SCL spike", rx_data[rx_n - 2], 8'hC3);

    // reads
    do_read(1);
    do_read(3);

    // random writes and reads
    for (int t = 0; t < 8; t++) begin
      int n;
      n = $urandom_range(0, 3);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      do_write(n, 0, 9);
    end
    for (int t = 0; t < 2; t++) do_read($urandom_range(1, 2));

    summary();
    $finish;
  end
endmodule